// File: doc/BRIEF.md
# Auto-Modifying Indirect Address Unit

This unit keeps three independent 12-bit pointers into a 4 KB data space that is split into sixteen 256-byte banks. Each pointer is reached in one of two ways. A byte write replaces either its low eight bits or its upper four bits. A full load replaces all twelve bits in a single cycle.

For each indirect data access, the requester names a pointer and an access mode. The unit then returns the registered 12-bit effective address together with a strobe. It also adjusts the named pointer as the mode requires. There are five modes: plain, post-increment, post-decrement, pre-increment, and an offset mode that adds the signed 8-bit working register. There is no pre-decrement mode. Its code, the other unused codes and an unknown pointer number are flagged as illegal and have no effect.

Top module: `iaddr_unit`

## Requirements
- R1: After a synchronous active-high reset, all three pointers are zero, and `mem_strobe` and `acc_illegal` are low.
- R2: A byte write with `wr_hi`=0 replaces pointer bits 7:0 with `wr_data`. With `wr_hi`=1 it replaces bits 11:8 with `wr_data[3:0]` and discards `wr_data[7:4]`. The other bits of the pointer are kept.
- R3: A full load writes all 12 bits of the chosen pointer. When a full load and a byte write target the same pointer in the same cycle, the full load wins.
- R4: `acc_mode` encoding: 0 plain, 1 post-increment, 2 post-decrement, 3 pre-increment, 4 working-register offset. For a legal access with `acc_en` high, the next cycle shows the address on `mem_addr` with `mem_strobe` high for one cycle. A plain access leaves the pointer unchanged.
- R5: Post-increment and post-decrement output the current pointer value, then add or subtract one.
- R6: Pre-increment adds one to the pointer and outputs the new value.
- R7: Offset mode outputs the pointer plus `wreg` read as a signed two's-complement byte, and leaves the pointer unchanged.
- R8: All pointer and address arithmetic wraps modulo 4096.
- R9: Mode codes 5 (pre-decrement), 6 and 7, and pointer number 3, are illegal. The next cycle shows `acc_illegal` high and `mem_strobe` low, `mem_addr` holds its previous value, and no pointer changes.
- R10: A byte write or full load to the pointer that an auto-modifying access uses in the same cycle wins over the update. The access address still comes from the value before the write.
- R11: An access changes only the pointer it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Pointer number for byte write |
| wr_hi | input | 1 | 0 writes the low byte, 1 writes the upper bits |
| wr_data | input | 8 | Byte write data |
| ld_en | input | 1 | Full load strobe |
| ld_sel | input | 2 | Pointer number for full load |
| ld_value | input | 12 | Full load value |
| acc_en | input | 1 | Data access request |
| acc_sel | input | 2 | Pointer number for the access |
| acc_mode | input | 3 | Access mode code |
| wreg | input | 8 | Working register, signed offset |
| mem_addr | output | 12 | Registered effective address |
| mem_strobe | output | 1 | Registered strobe for a legal access |
| acc_illegal | output | 1 | Registered flag for a rejected access |

## Verification
The bench aims at the edges of the 4096 space. It increments from 0xFFF and decrements from zero. It also uses offsets of -16, +127 and -128, which show whether the offset is sign-extended or zero-extended. Every mode is followed by a plain read, so an off-by-one update, a wrong ordering between pre- and post-update, or a changed pointer after an offset access shows up directly in the next address.

Illegal codes are probed with the pre-decrement code, the other unused codes and pointer 3. A design that let any of them through would raise the strobe or move a pointer. The bench also drives same-cycle collisions between a write and an auto-update, and between a full load and a byte write. A design with the wrong priority there would leave an incremented or half-written pointer.

// File: rtl/iaddr_pkg.sv
package iaddr_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_POSTDEC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_OFFSET  = 3'd4,
    AM_PREDEC  = 3'd5
  } amode_t;

  localparam int MODE_W = 3;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/iaddr_calc.sv
module iaddr_calc
  import iaddr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WREG_W = 8
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [MODE_W-1:0] mode,
  input  logic [WREG_W-1:0] wreg,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] nxt,
  output logic              upd,
  output logic              illegal
);
  localparam int EXT_W = ADDR_W - WREG_W;

  logic [ADDR_W-1:0] wreg_sx;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_dec;

  assign wreg_sx = {{EXT_W{wreg[WREG_W-1]}}, wreg};
  assign ptr_inc = ptr + ADDR_W'(1);
  assign ptr_dec = ptr - ADDR_W'(1);

  always_comb begin
    addr    = ptr;
    nxt     = ptr;
    upd     = 1'b0;
    illegal = 1'b0;
    case (amode_t'(mode))
      AM_PLAIN: ;
      AM_POSTINC: begin
        nxt = ptr_inc;
        upd = 1'b1;
      end
      AM_POSTDEC: begin
        nxt = ptr_dec;
        upd = 1'b1;
      end
      AM_PREINC: begin
        addr = ptr_inc;
        nxt  = ptr_inc;
        upd  = 1'b1;
      end
      AM_OFFSET: addr = ptr + wreg_sx;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/iaddr_ptr_reg.sv
module iaddr_ptr_reg
  import iaddr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_hit,
  input  logic [ADDR_W-1:0] ld_value,
  input  logic              wr_lo_hit,
  input  logic              wr_hi_hit,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              upd_hit,
  input  logic [ADDR_W-1:0] upd_value,
  output logic [ADDR_W-1:0] value
);
  localparam int HI_W = ADDR_W - BYTE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (ld_hit) begin
      value <= ld_value;
    end else if (wr_lo_hit) begin
      value[BYTE_W-1:0] <= wr_data;
    end else if (wr_hi_hit) begin
      value[ADDR_W-1:BYTE_W] <= wr_data[HI_W-1:0];
    end else if (upd_hit) begin
      value <= upd_value;
    end
  end
endmodule

// File: rtl/iaddr_unit.sv
module iaddr_unit
  import iaddr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WREG_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_value,
  input  logic              acc_en,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [MODE_W-1:0] acc_mode,
  input  logic [WREG_W-1:0] wreg,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_strobe,
  output logic              acc_illegal
);
  logic [ADDR_W-1:0] ptr_q [NUM_PTR];
  logic [ADDR_W-1:0] cur_ptr;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] nxt_ptr;
  logic              need_upd;
  logic              mode_bad;
  logic              sel_ok;
  logic              acc_ok;

  assign sel_ok = 32'(acc_sel) < NUM_PTR;

  always_comb begin
    cur_ptr = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (acc_sel == SEL_W'(i)) cur_ptr = ptr_q[i];
    end
  end

  iaddr_calc #(.ADDR_W(ADDR_W), .WREG_W(WREG_W)) u_calc (
    .ptr     (cur_ptr),
    .mode    (acc_mode),
    .wreg    (wreg),
    .addr    (eff_addr),
    .nxt     (nxt_ptr),
    .upd     (need_upd),
    .illegal (mode_bad)
  );

  assign acc_ok = sel_ok && !mode_bad;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic ld_hit;
    logic wr_lo_hit;
    logic wr_hi_hit;
    logic upd_hit;

    assign ld_hit    = ld_en && (ld_sel == SEL_W'(g));
    assign wr_lo_hit = wr_en && (wr_sel == SEL_W'(g)) && !wr_hi;
    assign wr_hi_hit = wr_en && (wr_sel == SEL_W'(g)) && wr_hi;
    assign upd_hit   = acc_en && acc_ok && need_upd && (acc_sel == SEL_W'(g));

    iaddr_ptr_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk       (clk),
      .rst       (rst),
      .ld_hit    (ld_hit),
      .ld_value  (ld_value),
      .wr_lo_hit (wr_lo_hit),
      .wr_hi_hit (wr_hi_hit),
      .wr_data   (wr_data),
      .upd_hit   (upd_hit),
      .upd_value (nxt_ptr),
      .value     (ptr_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr    <= '0;
      mem_strobe  <= 1'b0;
      acc_illegal <= 1'b0;
    end else begin
      mem_strobe  <= acc_en && acc_ok;
      acc_illegal <= acc_en && !acc_ok;
      if (acc_en && acc_ok) mem_addr <= eff_addr;
    end
  end
endmodule

// File: rtl/iaddr_unit_chk.sv
module iaddr_unit_chk
  import iaddr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WREG_W  = 8,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic              wr_hi,
  input logic [BYTE_W-1:0] wr_data,
  input logic              ld_en,
  input logic [SEL_W-1:0]  ld_sel,
  input logic [ADDR_W-1:0] ld_value,
  input logic              acc_en,
  input logic [SEL_W-1:0]  acc_sel,
  input logic [MODE_W-1:0] acc_mode,
  input logic [WREG_W-1:0] wreg,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_strobe,
  input logic              acc_illegal
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!mem_strobe && !acc_illegal));

  assert_strobe_legal_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_mode <= 3'd4 && 32'(acc_sel) < NUM_PTR) |=> (mem_strobe && !acc_illegal));

  assert_strobe_has_request_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_strobe || acc_illegal) |-> $past(acc_en));

  assert_no_predec_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_mode == AM_PREDEC) |=> (acc_illegal && !mem_strobe && $stable(mem_addr)));

  assert_exclusive_flags_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_strobe && acc_illegal));
endmodule

bind iaddr_unit iaddr_unit_chk #(
  .ADDR_W(ADDR_W), .WREG_W(WREG_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/test_iaddr_unit.sv
module test_iaddr_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_hi, ld_en, acc_en;
  logic [1:0]  wr_sel, ld_sel, acc_sel;
  logic [7:0]  wr_data, wreg;
  logic [11:0] ld_value, mem_addr;
  logic [2:0]  acc_mode;
  logic        mem_strobe, acc_illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  iaddr_unit i_iaddr_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
    .wr_data(wr_data), .ld_en(ld_en), .ld_sel(ld_sel), .ld_value(ld_value),
    .acc_en(acc_en), .acc_sel(acc_sel), .acc_mode(acc_mode), .wreg(wreg),
    .mem_addr(mem_addr), .mem_strobe(mem_strobe), .acc_illegal(acc_illegal)
  );

  // kind: 0 load, 1 byte write (mode bit0 = upper), 2 access
  function automatic logic [44:0] mk(input logic [1:0] kind, input logic [1:0] sel,
      input logic [2:0] mode, input logic [11:0] data, input logic [7:0] w,
      input logic es, input logic ei, input logic [11:0] ea, input logic [3:0] req);
    return {kind, sel, mode, data, w, es, ei, ea, req};
  endfunction

  localparam int NV = 35;
  localparam logic [44:0] VEC [NV] = '{
    mk(2, 0, 0, 0, 0, 1, 0, 12'h000, 1),       // R1 reset pointers
    mk(2, 1, 0, 0, 0, 1, 0, 12'h000, 1),       // R1
    mk(2, 2, 0, 0, 0, 1, 0, 12'h000, 1),       // R1
    mk(0, 0, 0, 12'h123, 0, 0, 0, 0, 3),       // R3 full load
    mk(2, 0, 1, 0, 0, 1, 0, 12'h123, 5),       // R5 post-inc
    mk(2, 0, 0, 0, 0, 1, 0, 12'h124, 5),
    mk(2, 0, 2, 0, 0, 1, 0, 12'h124, 5),       // R5 post-dec
    mk(2, 0, 0, 0, 0, 1, 0, 12'h123, 5),
    mk(2, 0, 3, 0, 0, 1, 0, 12'h124, 6),       // R6 pre-inc
    mk(2, 0, 0, 0, 0, 1, 0, 12'h124, 6),
    mk(0, 1, 0, 12'hFFF, 0, 0, 0, 0, 8),       // R8 wrap up
    mk(2, 1, 1, 0, 0, 1, 0, 12'hFFF, 8),
    mk(2, 1, 0, 0, 0, 1, 0, 12'h000, 8),
    mk(2, 1, 2, 0, 0, 1, 0, 12'h000, 8),       // R8 wrap down
    mk(2, 1, 0, 0, 0, 1, 0, 12'hFFF, 8),
    mk(0, 2, 0, 12'h010, 0, 0, 0, 0, 7),       // R7 signed offset
    mk(2, 2, 4, 0, 8'hF0, 1, 0, 12'h000, 7),
    mk(2, 2, 0, 0, 0, 1, 0, 12'h010, 7),
    mk(2, 2, 4, 0, 8'h7F, 1, 0, 12'h08F, 7),
    mk(0, 2, 0, 12'h005, 0, 0, 0, 0, 8),
    mk(2, 2, 4, 0, 8'h80, 1, 0, 12'hF85, 8),   // R8 offset wraps
    mk(1, 0, 0, 12'h0AB, 0, 0, 0, 0, 2),       // R2 low byte
    mk(2, 0, 0, 0, 0, 1, 0, 12'h1AB, 2),
    mk(1, 0, 1, 12'h0FE, 0, 0, 0, 0, 2),       // R2 upper bits, 7:4 dropped
    mk(2, 0, 0, 0, 0, 1, 0, 12'hEAB, 2),
    mk(2, 0, 5, 0, 0, 0, 1, 12'hEAB, 9),       // R9 pre-decrement rejected
    mk(2, 0, 0, 0, 0, 1, 0, 12'hEAB, 9),
    mk(2, 1, 6, 0, 0, 0, 1, 12'hEAB, 9),
    mk(2, 2, 7, 0, 0, 0, 1, 12'hEAB, 9),
    mk(2, 3, 0, 0, 0, 0, 1, 12'hEAB, 9),       // R9 pointer 3
    mk(2, 2, 3, 0, 0, 1, 0, 12'h006, 11),      // R11 independence
    mk(2, 0, 0, 0, 0, 1, 0, 12'hEAB, 11),
    mk(2, 1, 0, 0, 0, 1, 0, 12'hFFF, 11),
    mk(2, 0, 4, 0, 8'h01, 1, 0, 12'hEAC, 4),   // R4 offset code 4
    mk(2, 0, 0, 0, 0, 1, 0, 12'hEAB, 4)
  };

  task automatic idle();
    wr_en = 0; ld_en = 0; acc_en = 0; wr_hi = 0;
    wr_sel = 0; ld_sel = 0; acc_sel = 0; acc_mode = 0;
    wr_data = 0; ld_value = 0; wreg = 0;
  endtask

  task automatic check(input string req, input logic es, input logic ei, input logic [11:0] ea);
    checks++;
    if (mem_strobe !== es || acc_illegal !== ei || (mem_addr !== ea)) begin
      errors++;
      $display("FAIL %s: strobe=%0b illegal=%0b addr=%03h expected strobe=%0b illegal=%0b addr=%03h",
               req, mem_strobe, acc_illegal, mem_addr, es, ei, ea);
    end
  endtask

  task automatic access(input logic [1:0] s, input logic [2:0] m, input logic [7:0] w);
    @(negedge clk);
    idle();
    acc_en = 1; acc_sel = s; acc_mode = m; wreg = w;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 12'h000);
    rst = 0;
    @(negedge clk);
    check("R1", 0, 0, 12'h000);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      @(negedge clk);
      idle();
      case (v[44:43])
        2'd0: begin ld_en = 1; ld_sel = v[42:41]; ld_value = v[37:26]; end
        2'd1: begin wr_en = 1; wr_sel = v[42:41]; wr_hi = v[38]; wr_data = v[33:26]; end
        default: begin acc_en = 1; acc_sel = v[42:41]; acc_mode = v[40:38]; wreg = v[25:18]; end
      endcase
      @(negedge clk);
      idle();
      if (v[44:43] == 2'd2)
        check($sformatf("R%0d vector %0d", v[3:0], i), v[17], v[16], v[15:4]);
    end

    // R10: post-increment of p0 (EAB) with a low-byte write to p0 in the same cycle
    @(negedge clk);
    idle();
    acc_en = 1; acc_sel = 0; acc_mode = 3'd1;
    wr_en = 1; wr_sel = 0; wr_hi = 0; wr_data = 8'h11;
    @(negedge clk);
    idle();
    check("R10 address from old value", 1, 0, 12'hEAB);
    access(0, 0, 0);
    check("R10 write wins over increment", 1, 0, 12'hE11);

    // R10: pre-increment of p2 (006) with a full load in the same cycle
    @(negedge clk);
    idle();
    acc_en = 1; acc_sel = 2; acc_mode = 3'd3;
    ld_en = 1; ld_sel = 2; ld_value = 12'h700;
    @(negedge clk);
    idle();
    check("R10 pre-inc address", 1, 0, 12'h007);
    access(2, 0, 0);
    check("R10 load wins over pre-inc", 1, 0, 12'h700);

    // R3: full load and byte write to p1 in the same cycle
    @(negedge clk);
    idle();
    ld_en = 1; ld_sel = 1; ld_value = 12'h234;
    wr_en = 1; wr_sel = 1; wr_hi = 1; wr_data = 8'h0F;
    @(negedge clk);
    idle();
    access(1, 0, 0);
    check("R3 load beats byte write", 1, 0, 12'h234);

    // R9: illegal access leaves pointer untouched, then idle drops strobe
    access(1, 5, 0);
    check("R9 pre-decrement flagged", 0, 1, 12'h234);
    access(1, 0, 0);
    check("R9 pointer unchanged", 1, 0, 12'h234);
    @(negedge clk);
    check("R4 strobe lasts one cycle", 0, 0, 12'h234);

    // R1: reset in mid-run clears pointers
    rst = 1;
    @(negedge clk);
    check("R1 outputs in reset", 0, 0, 12'h000);
    rst = 0;
    access(1, 0, 0);
    check("R1 pointer cleared", 1, 0, 12'h000);
    access(0, 0, 0);
    check("R1 pointer cleared", 1, 0, 12'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule